// File: doc/BRIEF.md
# Dual-Request ADC Trigger Arbiter

This block sequences a single shared analog-to-digital converter between two independent conversion requests, a primary one (index 0) and a secondary one (index 1). Either request may be launched by a software start bit or by one shared asynchronous hardware trigger line. The trigger line is synchronized and edge-detected, and each request then applies its own arming, one-shot and drop-when-busy rules to the edge. A global ignore bit blinds the block to the line, and a global enable bit gates every source.

When both requests want the converter, the one that became pending first is served first. Requests that become pending in the same cycle are ordered by a fixed tie rule. A hardware trigger that lands while the converter is busy is either dropped or held, chosen per request. A held trigger launches in the cycle right after the running conversion ends. The converter itself is modelled inside the block: a one-cycle start, a fixed number of busy cycles and a done pulse. Each request owns a sticky done flag, which is cleared by writing 1 and can be masked from its interrupt output.

Top module: `adc_trig_arbiter`

## Requirements
- R1: A rising edge on `hw_trig_in` passes through `SYNC_STAGES` flops before it counts as a trigger event. For an armed, idle request, `conv_start` rises `SYNC_STAGES`+1 cycles after the cycle in which the input rose. A software start pulse gives `conv_start` in the following cycle.
- R2: Pending requests are served in order of arrival, so a secondary request that became pending before the primary one converts first.
- R3: A trigger event that reaches request i while `conv_busy` is high is discarded if `cfg_drop_busy[i]` is 1.
- R4: If `cfg_drop_busy[i]` is 0, that trigger is held, and its `conv_start` comes in the cycle right after the `conv_done` cycle, which is `BUSY_CYCLES`+1 cycles after the previous start.
- R5: Software starts are held whatever `cfg_drop_busy` says. `sw_pending[i]` stays 1 from the start pulse until request i is launched, and then returns to 0.
- R6: With `cfg_oneshot[i]` set, request i accepts only the first hardware trigger event after arming. Later events are dropped, and software starts still work.
- R7: Clearing `cfg_oneshot[i]` for at least one cycle and setting it again re-arms request i for one more hardware trigger.
- R8: When both requests become pending in the same cycle, the primary one goes first, unless `cfg_drop_busy` = 2'b10, in which case the secondary one goes first.
- R9: While `cfg_trig_ignore` is 1, edges on `hw_trig_in` launch nothing.
- R10: While `cfg_enable` is 0, no conversion starts, start pulses and trigger events are discarded, and requests already pending are flushed.
- R11: `conv_start` is a one-cycle pulse that is issued only while `conv_busy` is low. `conv_busy` is then high for exactly `BUSY_CYCLES` cycles, and `conv_done` is high in the last of them. `conv_sel` gives the request (0 primary, 1 secondary) being started or converted.
- R12: `irq_flag[i]` sets when a conversion of request i completes and stays set until `irq_clear[i]` is pulsed. `irq[i]` is `irq_flag[i]` gated off by `cfg_irq_mask[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Global enable for all start sources |
| cfg_trig_ignore | input | 1 | Disregard the hardware trigger line |
| cfg_hw_arm | input | 2 | Request i listens to the hardware trigger |
| cfg_drop_busy | input | 2 | 1: drop a busy-time trigger for request i; 0: hold it |
| cfg_oneshot | input | 2 | Accept a single hardware trigger per arming |
| cfg_irq_mask | input | 2 | Mask the done interrupt of request i |
| sw_start | input | 2 | Software start pulse per request |
| irq_clear | input | 2 | Write-1 pulse clearing the done flag |
| hw_trig_in | input | 1 | Asynchronous hardware trigger line |
| conv_start | output | 1 | Converter start pulse |
| conv_sel | output | 1 | Request being started or converted |
| conv_busy | output | 1 | Converter busy |
| conv_done | output | 1 | Converter done pulse (last busy cycle) |
| sw_pending | output | 2 | Self-clearing software start bits |
| irq_flag | output | 2 | Sticky done flags |
| irq | output | 2 | Masked done interrupts |

## Verification
The bench builds the block with `BUSY_CYCLES` = 4 and `SYNC_STAGES` = 2. At these values the trigger latency is 3 cycles and the start-to-start spacing is 5 cycles, and a queue of three conversions drains in about fifteen cycles. This keeps every arrival-order case within reach of short directed sequences: trigger before, during and at the end of a conversion. It also allows a full sweep over all four drop-when-busy settings for simultaneous arrivals, and a full one-shot arm, use and re-arm cycle.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

   localparam int unsigned NUM_REQ = 2;

   typedef logic [NUM_REQ-1:0] req_vec_t;

   // Ordering when both requests appear in the same cycle: the secondary
   // request leads only when it alone is in drop-when-busy mode.
   function automatic logic pick_on_tie(input req_vec_t drop_busy);
      return drop_busy[1] & ~drop_busy[0];
   endfunction

   // Request to launch given the pending set and the age bit.
   function automatic logic pick_launch(input req_vec_t pend, input logic older);
      return (&pend) ? older : pend[1];
   endfunction

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_async,
   output logic trig_rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("adc_trig_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], trig_async};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign trig_rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/adc_trig_conv.sv
module adc_trig_conv #(
   parameter int unsigned BUSY_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("adc_trig_conv: BUSY_CYCLES must be at least 1");
   end

   if (BUSY_CYCLES == 1) begin : g_single
      logic run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) run_q <= 1'b0;
         else        run_q <= start;
      end

      assign busy = run_q;
      assign done = run_q;
   end else begin : g_count
      localparam int unsigned CW = $clog2(BUSY_CYCLES);

      logic          run_q;
      logic [CW-1:0] left_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q  <= 1'b0;
            left_q <= '0;
         end else if (start && !run_q) begin
            run_q  <= 1'b1;
            left_q <= CW'(BUSY_CYCLES - 1);
         end else if (run_q) begin
            if (left_q == '0) run_q  <= 1'b0;
            else              left_q <= left_q - 1'b1;
         end
      end

      assign busy = run_q;
      assign done = run_q && (left_q == '0);
   end

endmodule

// File: rtl/adc_trig_slot.sv
module adc_trig_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic trig_rise,
   input  logic hw_arm,
   input  logic drop_busy,
   input  logic oneshot,
   input  logic conv_busy,
   input  logic sw_set,
   input  logic launch,
   input  logic irq_clr,
   input  logic done_mine,
   output logic pend,
   output logic arrive,
   output logic sw_req,
   output logic irq_flag
);

   logic hw_pend_q;
   logic sw_q;
   logic shot_used_q;
   logic irq_q;
   logic shot_block;
   logic hw_acc;

   assign shot_block = oneshot & shot_used_q;
   assign hw_acc     = enable & trig_rise & hw_arm & ~shot_block
                     & ~(conv_busy & drop_busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hw_pend_q   <= 1'b0;
         sw_q        <= 1'b0;
         shot_used_q <= 1'b0;
         irq_q       <= 1'b0;
      end else begin
         if (!enable) begin
            hw_pend_q <= 1'b0;
            sw_q      <= 1'b0;
         end else begin
            hw_pend_q <= (hw_pend_q & ~launch) | hw_acc;
            sw_q      <= (sw_q & ~launch) | sw_set;
         end
         if (!oneshot) shot_used_q <= 1'b0;
         else          shot_used_q <= shot_used_q | hw_acc;
         irq_q <= (irq_q & ~irq_clr) | done_mine;
      end
   end

   assign pend     = hw_pend_q | sw_q;
   assign arrive   = hw_acc | (enable & sw_set);
   assign sw_req   = sw_q;
   assign irq_flag = irq_q;

endmodule

// File: rtl/adc_trig_arbiter.sv
module adc_trig_arbiter
   import adc_trig_pkg::*;
#(
   parameter int unsigned BUSY_CYCLES = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic               cfg_trig_ignore,
   input  logic [NUM_REQ-1:0] cfg_hw_arm,
   input  logic [NUM_REQ-1:0] cfg_drop_busy,
   input  logic [NUM_REQ-1:0] cfg_oneshot,
   input  logic [NUM_REQ-1:0] cfg_irq_mask,
   input  logic [NUM_REQ-1:0] sw_start,
   input  logic [NUM_REQ-1:0] irq_clear,
   input  logic               hw_trig_in,
   output logic               conv_start,
   output logic               conv_sel,
   output logic               conv_busy,
   output logic               conv_done,
   output logic [NUM_REQ-1:0] sw_pending,
   output logic [NUM_REQ-1:0] irq_flag,
   output logic [NUM_REQ-1:0] irq
);

   logic     trig_rise;
   logic     trig_ok;
   logic     busy;
   logic     done;
   logic     launch;
   logic     sel;
   logic     older_q;
   logic     older_d;
   logic     owner_q;
   req_vec_t pend;
   req_vec_t arrive;
   req_vec_t kept;
   req_vec_t launch_vec;
   req_vec_t done_vec;

   adc_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_async (hw_trig_in),
      .trig_rise  (trig_rise)
   );

   assign trig_ok = trig_rise & ~cfg_trig_ignore;

   assign launch = cfg_enable & ~busy & (|pend);
   assign sel    = pick_launch(pend, older_q);

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
      assign launch_vec[i] = launch && (sel == 1'(i));
      assign done_vec[i]   = done && (owner_q == 1'(i));

      adc_trig_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (cfg_enable),
         .trig_rise (trig_ok),
         .hw_arm    (cfg_hw_arm[i]),
         .drop_busy (cfg_drop_busy[i]),
         .oneshot   (cfg_oneshot[i]),
         .conv_busy (busy),
         .sw_set    (sw_start[i]),
         .launch    (launch_vec[i]),
         .irq_clr   (irq_clear[i]),
         .done_mine (done_vec[i]),
         .pend      (pend[i]),
         .arrive    (arrive[i]),
         .sw_req    (sw_pending[i]),
         .irq_flag  (irq_flag[i])
      );
   end

   // Age tracking: one bit names the older of two waiting requests.
   assign kept = pend & ~launch_vec;

   always_comb begin
      older_d = older_q;
      if (&(kept | arrive)) begin
         if (&kept)        older_d = older_q;
         else if (kept[0]) older_d = 1'b0;
         else if (kept[1]) older_d = 1'b1;
         else              older_d = pick_on_tie(cfg_drop_busy);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older_q <= 1'b0;
         owner_q <= 1'b0;
      end else begin
         older_q <= older_d;
         if (launch) owner_q <= sel;
      end
   end

   adc_trig_conv #(.BUSY_CYCLES(BUSY_CYCLES)) u_conv (
      .clk   (clk),
      .rst_n (rst_n),
      .start (launch),
      .busy  (busy),
      .done  (done)
   );

   assign conv_start = launch;
   assign conv_sel   = launch ? sel : owner_q;
   assign conv_busy  = busy;
   assign conv_done  = done;
   assign irq        = irq_flag & ~cfg_irq_mask;

endmodule

// File: rtl/adc_trig_arbiter_chk.sv
module adc_trig_arbiter_chk #(
   parameter int unsigned BUSY_CYCLES = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_enable,
   input logic       conv_start,
   input logic       conv_sel,
   input logic       conv_busy,
   input logic       conv_done,
   input logic [1:0] irq_clear,
   input logic [1:0] irq_flag
);

   localparam int unsigned RW = $clog2(BUSY_CYCLES + 1) + 1;

   logic [RW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_cnt <= '0;
      else if (conv_start) run_cnt <= RW'(1);
      else if (conv_busy)  run_cnt <= run_cnt + 1'b1;
   end

   a_r11_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !conv_busy);

   a_r11_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> conv_busy);

   a_r11_done_length: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> (run_cnt == RW'(BUSY_CYCLES)));

   a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> !conv_busy);

   a_r11_done_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> conv_busy);

   a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |-> !conv_start);

   for (genvar i = 0; i < 2; i++) begin : g_irq
      a_r12_flag_from_done: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_flag[i]) |-> ($past(conv_done) && ($past(conv_sel) == 1'(i))));

      a_r12_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_clear[i] && !(conv_done && (conv_sel == 1'(i)))) |=> !irq_flag[i]);
   end

endmodule

bind adc_trig_arbiter adc_trig_arbiter_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_enable (cfg_enable),
   .conv_start (conv_start),
   .conv_sel   (conv_sel),
   .conv_busy  (conv_busy),
   .conv_done  (conv_done),
   .irq_clear  (irq_clear),
   .irq_flag   (irq_flag)
);

// File: tb/adc_trig_arbiter_tb_top.sv
`timescale 1ns/100ps
module adc_trig_arbiter_tb_top;

   localparam int BUSY   = 4;
   localparam int SYNC   = 2;
   localparam int GAP    = BUSY + 1;
   localparam int HW_LAT = SYNC + 1;
   localparam int SW_LAT = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_enable = 1'b0;
   logic       cfg_trig_ignore = 1'b0;
   logic [1:0] cfg_hw_arm = '0;
   logic [1:0] cfg_drop_busy = '0;
   logic [1:0] cfg_oneshot = '0;
   logic [1:0] cfg_irq_mask = '0;
   logic [1:0] sw_start = '0;
   logic [1:0] irq_clear = '0;
   logic       hw_trig_in = 1'b0;
   logic       conv_start, conv_sel, conv_busy, conv_done;
   logic [1:0] sw_pending, irq_flag, irq;

   always #2 clk = ~clk;

   adc_trig_arbiter #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
      .cfg_trig_ignore(cfg_trig_ignore), .cfg_hw_arm(cfg_hw_arm),
      .cfg_drop_busy(cfg_drop_busy), .cfg_oneshot(cfg_oneshot),
      .cfg_irq_mask(cfg_irq_mask), .sw_start(sw_start), .irq_clear(irq_clear),
      .hw_trig_in(hw_trig_in), .conv_start(conv_start), .conv_sel(conv_sel),
      .conv_busy(conv_busy), .conv_done(conv_done), .sw_pending(sw_pending),
      .irq_flag(irq_flag), .irq(irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int n_starts = 0;
   int log_sel [16];
   int log_cyc [16];
   bit finished = 1'b0;

   // Start monitor, sampling one ns after each falling edge.
   always begin
      @(negedge clk);
      #1;
      if (rst_n && conv_start) begin
         if (n_starts < 16) begin
            log_sel[n_starts] = int'(conv_sel);
            log_cyc[n_starts] = cyc;
         end
         n_starts++;
      end
      cyc++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic settle;
      @(negedge clk);
      #1.5;
   endtask

   task automatic fresh;
      tick(2);
      n_starts = 0;
   endtask

   task automatic trig_pulse(output int at);
      @(negedge clk);
      hw_trig_in = 1'b1;
      at = cyc;
      repeat (2) @(negedge clk);
      hw_trig_in = 1'b0;
   endtask

   task automatic sw_pulse(input int idx, output int at);
      @(negedge clk);
      sw_start[idx] = 1'b1;
      at = cyc;
      @(negedge clk);
      sw_start = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int t0;
      int t1;
      tick(3);
      rst_n = 1'b1;

      // Reset state (R11, R12, R5)
      settle;
      chk("R11 reset conv_busy", int'(conv_busy), 0);
      chk("R11 reset conv_start", int'(conv_start), 0);
      chk("R12 reset irq_flag", int'(irq_flag), 0);
      chk("R12 reset irq", int'(irq), 0);
      chk("R5 reset sw_pending", int'(sw_pending), 0);

      // R10: disabled block ignores every source and keeps nothing
      fresh;
      cfg_hw_arm = 2'b11;
      sw_pulse(0, t0);
      sw_pulse(1, t0);
      trig_pulse(t0);
      tick(10);
      chk("R10 no start while disabled", n_starts, 0);
      settle;
      chk("R10 start bits dropped", int'(sw_pending), 0);
      cfg_enable = 1'b1;
      tick(15);
      chk("R10 nothing launched after enable", n_starts, 0);

      // R9: ignore bit blinds the trigger line
      fresh;
      cfg_trig_ignore = 1'b1;
      trig_pulse(t0);
      tick(15);
      chk("R9 ignored trigger", n_starts, 0);
      cfg_trig_ignore = 1'b0;
      tick(3);

      // R8 / R1 / R4: simultaneous arrival swept over all drop settings
      for (int m = 0; m < 4; m++) begin
         int exp_first;
         cfg_drop_busy = 2'(m);
         fresh;
         trig_pulse(t0);
         tick(20);
         exp_first = (m == 2) ? 1 : 0;
         chk($sformatf("R8 tie starts drop=%0d", m), n_starts, 2);
         chk($sformatf("R8 tie first drop=%0d", m), log_sel[0], exp_first);
         chk($sformatf("R8 tie second drop=%0d", m), log_sel[1], 1 - exp_first);
         chk($sformatf("R1 trigger latency drop=%0d", m), log_cyc[0] - t0, HW_LAT);
         chk($sformatf("R4 back-to-back gap drop=%0d", m), log_cyc[1] - log_cyc[0], GAP);
      end

      // R12: done flags, mask and write-1 clear
      irq_clear = 2'b11;
      tick(1);
      irq_clear = 2'b00;
      cfg_hw_arm = 2'b00;
      fresh;
      sw_pulse(0, t0);
      tick(10);
      chk("R1 software latency", log_cyc[0] - t0, SW_LAT);
      settle;
      chk("R12 flag of finished request", int'(irq_flag), 1);
      chk("R12 unmasked irq", int'(irq), 1);
      cfg_irq_mask = 2'b01;
      settle;
      chk("R12 masked irq low", int'(irq), 0);
      chk("R12 masked flag kept", int'(irq_flag), 1);
      @(negedge clk);
      irq_clear = 2'b01;
      @(negedge clk);
      irq_clear = 2'b00;
      settle;
      chk("R12 flag cleared", int'(irq_flag), 0);
      cfg_irq_mask = 2'b00;

      // R3 / R4: trigger for the secondary during a primary conversion
      for (int m = 0; m < 2; m++) begin
         cfg_hw_arm = 2'b10;
         cfg_drop_busy = {1'(m), 1'b0};
         fresh;
         sw_pulse(0, t0);
         trig_pulse(t1);
         tick(20);
         if (m == 1) begin
            chk("R3 busy trigger dropped", n_starts, 1);
         end else begin
            chk("R4 busy trigger held", n_starts, 2);
            chk("R4 held request identity", log_sel[1], 1);
            chk("R4 held start right after done", log_cyc[1] - log_cyc[0], GAP);
         end
      end

      // R5: software start not subject to drop setting
      cfg_hw_arm = 2'b00;
      cfg_drop_busy = 2'b11;
      fresh;
      sw_pulse(0, t0);
      sw_pulse(1, t1);
      settle;
      chk("R5 start bit held while busy", int'(sw_pending[1]), 1);
      tick(20);
      chk("R5 software start kept", n_starts, 2);
      chk("R5 second start gap", log_cyc[1] - log_cyc[0], GAP);
      settle;
      chk("R5 start bits self-clear", int'(sw_pending), 0);

      // R6 / R7: one-shot arming
      cfg_hw_arm = 2'b01;
      cfg_drop_busy = 2'b00;
      cfg_oneshot = 2'b01;
      fresh;
      trig_pulse(t0);
      tick(15);
      chk("R6 first trigger accepted", n_starts, 1);
      fresh;
      trig_pulse(t0);
      tick(15);
      chk("R6 later trigger dropped", n_starts, 0);
      fresh;
      sw_pulse(0, t0);
      tick(10);
      chk("R6 software start unaffected", n_starts, 1);
      cfg_oneshot = 2'b00;
      tick(2);
      cfg_oneshot = 2'b01;
      fresh;
      trig_pulse(t0);
      tick(15);
      chk("R7 re-armed trigger accepted", n_starts, 1);
      cfg_oneshot = 2'b00;

      // R2: arrival order beats primary preference
      cfg_hw_arm = 2'b01;
      cfg_drop_busy = 2'b00;
      fresh;
      sw_pulse(0, t0);
      @(negedge clk);
      sw_start[1] = 1'b1;
      hw_trig_in = 1'b1;
      @(negedge clk);
      sw_start = '0;
      @(negedge clk);
      hw_trig_in = 1'b0;
      tick(25);
      chk("R2 three conversions", n_starts, 3);
      chk("R2 first primary", log_sel[0], 0);
      chk("R2 older secondary next", log_sel[1], 1);
      chk("R2 younger primary last", log_sel[2], 0);
      chk("R2 final gap", log_cyc[2] - log_cyc[1], GAP);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule